// File: doc/BRIEF.md
# Masked OR Trigger Output Shaper

This block drives two trigger output lines, meant for a front-panel and a back-panel connector. Discriminator inputs come in groups of 16 channels (three groups, A, B and C, by default). Each channel is gated by its own enable bit. Each output then forms the OR of the groups that its own 3-bit group mask selects. A rising edge of that OR starts an output pulse with a programmable high time. A programmable dead time follows, and any input activity during the pulse or the dead time is dropped rather than kept for later.

Both outputs share one pair of 4-bit timing fields. With a 5 ns clock, a field value N gives (5·N + 10) ns, which is N+2 clock cycles. Writing the fields alone changes nothing. The block copies them into its working timing registers only when a one-cycle output-reset strobe arrives. That strobe also returns both pulse generators to idle, with their outputs low. The chip reset sets the working timing to N = 0.

Top module: `trig_out_shaper`

## Requirements
- R1: Bit 0 of an output's group mask selects group A (channels 0-15), bit 1 group B (16-31) and bit 2 group C (32-47). Output k uses bits [3k+2:3k] of `out_mask`, so mask 3'b111 responds to all groups and 3'b010 only to group B.
- R2: A channel whose bit in `chan_en` is 0 never contributes to any output's OR.
- R3: An accepted trigger drives the output high for exactly (working high N)+2 cycles. It goes high in the cycle after the clock edge at which the rising OR was sampled.
- R4: After the high time the output stays low for a dead time of (working dead N)+2 cycles. Rising edges sampled during the high or the dead time are ignored and are not queued. The first edge that can be accepted is the one sampled high+dead+5 cycles after the accepting edge.
- R5: Only a rising edge of the masked OR starts a pulse. An OR level held high never retriggers.
- R6: Changes to `high_sel` and `dead_sel` have no effect until `out_rst` is sampled high. After `rst` the working values are both 0.
- R7: `out_rst` forces both outputs low from the next cycle and returns them to idle. A rising edge sampled one cycle later is accepted again.
- R8: The two outputs have independent masks and pulse timers but use the same working timing.
- R9: While and after `rst`, both outputs are low until a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disc_in | input | N_GROUPS*GROUP_W (48) | Discriminator levels, group A in the low bits |
| chan_en | input | N_GROUPS*GROUP_W (48) | Per-channel enable, 1 = contributes |
| out_mask | input | N_OUTS*N_GROUPS (6) | Group masks, output k at bits [3k+2:3k] |
| high_sel | input | 4 | High-time field N, pulse = N+2 cycles |
| dead_sel | input | 4 | Dead-time field N, dead = N+2 cycles |
| out_rst | input | 1 | One-cycle strobe: idle outputs, load timing fields |
| trig_out | output | N_OUTS (2) | Shaped trigger outputs, bit 0 front, bit 1 back |

## Verification
A wrong down-counter load or terminal test shows up at the port as a pulse one cycle too long or too short, visible on the first trigger after the timing changes. A dead state that ends early lets a second pulse appear inside the dead window. A stale working timing register shows up as a pulse width that ignores a completed output reset, or that follows the fields without one. The scoreboard fixes, for every pulse, the cycle it must start in and the exact width it must have. Any of these faults therefore shows as a mismatch within one pulse of its cause.

// File: rtl/trig_shaper_pkg.sv
package trig_shaper_pkg;

    localparam int GROUP_W_DEF  = 16;
    localparam int N_GROUPS_DEF = 3;
    localparam int N_OUTS_DEF   = 2;
    localparam int SEL_W        = 4;
    localparam int FIXED_CYC    = 2;
    localparam int CNT_W        = SEL_W + 1;

    typedef enum logic [1:0] {
        SHP_IDLE = 2'd0,
        SHP_HIGH = 2'd1,
        SHP_DEAD = 2'd2
    } shp_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] high_n;
        logic [SEL_W-1:0] dead_n;
    } shp_timing_t;

    // Down-counter load so that counting to zero spans n + FIXED_CYC cycles.
    function automatic logic [CNT_W-1:0] span_load(input logic [SEL_W-1:0] n);
        return CNT_W'(n) + CNT_W'(FIXED_CYC - 1);
    endfunction

endpackage

// File: rtl/masked_group_or.sv
module masked_group_or
    import trig_shaper_pkg::*;
#(
    parameter int GROUP_W  = GROUP_W_DEF,
    parameter int N_GROUPS = N_GROUPS_DEF
) (
    input  logic [N_GROUPS*GROUP_W-1:0] disc,
    input  logic [N_GROUPS*GROUP_W-1:0] en,
    input  logic [N_GROUPS-1:0]         grp_mask,
    output logic                        or_o
);
    logic [N_GROUPS-1:0] grp_hit;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        assign grp_hit[g] = |(disc[g*GROUP_W +: GROUP_W] & en[g*GROUP_W +: GROUP_W]);
    end

    assign or_o = |(grp_hit & grp_mask);

endmodule

// File: rtl/trig_pulse_fsm.sv
module trig_pulse_fsm
    import trig_shaper_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        trig_lvl,
    input  shp_timing_t timing,
    output logic        pulse_o
);
    shp_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             lvl_q;
    logic             rise;

    assign rise    = trig_lvl & ~lvl_q;
    assign pulse_o = (state == SHP_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SHP_IDLE;
            cnt   <= '0;
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= trig_lvl;
            if (clr) begin
                state <= SHP_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    SHP_IDLE: begin
                        if (rise) begin
                            state <= SHP_HIGH;
                            cnt   <= span_load(timing.high_n);
                        end
                    end
                    SHP_HIGH: begin
                        if (cnt == '0) begin
                            state <= SHP_DEAD;
                            cnt   <= span_load(timing.dead_n);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SHP_DEAD: begin
                        if (cnt == '0) state <= SHP_IDLE;
                        else           cnt   <= cnt - 1'b1;
                    end
                    default: begin
                        state <= SHP_IDLE;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(rise)); // R5
    AST_DEAD_NO_RETRIG: assert property (@(posedge clk) disable iff (rst)
        (state == SHP_DEAD && !clr) |=> (state != SHP_HIGH)); // R4
    AST_CLR_IDLES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!pulse_o && state == SHP_IDLE)); // R7
    AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == SHP_HIGH) |-> (cnt <= span_load(timing.high_n))); // R3

endmodule

// File: rtl/trig_out_shaper.sv
module trig_out_shaper
    import trig_shaper_pkg::*;
#(
    parameter int GROUP_W  = GROUP_W_DEF,
    parameter int N_GROUPS = N_GROUPS_DEF,
    parameter int N_OUTS   = N_OUTS_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_GROUPS*GROUP_W-1:0]  disc_in,
    input  logic [N_GROUPS*GROUP_W-1:0]  chan_en,
    input  logic [N_OUTS*N_GROUPS-1:0]   out_mask,
    input  logic [SEL_W-1:0]             high_sel,
    input  logic [SEL_W-1:0]             dead_sel,
    input  logic                         out_rst,
    output logic [N_OUTS-1:0]            trig_out
);
    shp_timing_t       work;
    logic [N_OUTS-1:0] or_lvl;

    always_ff @(posedge clk) begin
        if (rst)          work <= '0;
        else if (out_rst) work <= '{high_n: high_sel, dead_n: dead_sel};
    end

    for (genvar k = 0; k < N_OUTS; k++) begin : g_out
        masked_group_or #(
            .GROUP_W (GROUP_W),
            .N_GROUPS(N_GROUPS)
        ) u_or (
            .disc    (disc_in),
            .en      (chan_en),
            .grp_mask(out_mask[k*N_GROUPS +: N_GROUPS]),
            .or_o    (or_lvl[k])
        );

        trig_pulse_fsm u_fsm (
            .clk     (clk),
            .rst     (rst),
            .clr     (out_rst),
            .trig_lvl(or_lvl[k]),
            .timing  (work),
            .pulse_o (trig_out[k])
        );
    end

    AST_TIMING_HELD: assert property (@(posedge clk) disable iff (rst)
        !out_rst |=> $stable(work)); // R6
    AST_TIMING_LOAD: assert property (@(posedge clk) disable iff (rst)
        out_rst |=> (work.high_n == $past(high_sel) && work.dead_n == $past(dead_sel))); // R6

endmodule

// File: tb/tb_trig_out_shaper.sv
module tb_trig_out_shaper;

    localparam int NCH = 48;

    typedef struct {
        int    start;
        int    width;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  disc_in = '0;
    logic [NCH-1:0]  chan_en = '1;
    logic [5:0]      out_mask = '0;
    logic [3:0]      high_sel = '0;
    logic [3:0]      dead_sel = '0;
    logic            out_rst = 1'b0;
    logic [1:0]      trig_out;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    int   hw = 0, dw = 0;
    int   ready [2];
    exp_t q0 [$];
    exp_t q1 [$];
    logic prev_o [2];
    int   start_o [2];

    trig_out_shaper dut (
        .clk(clk), .rst(rst), .disc_in(disc_in), .chan_en(chan_en),
        .out_mask(out_mask), .high_sel(high_sel), .dead_sel(dead_sel),
        .out_rst(out_rst), .trig_out(trig_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push_exp(input int o, input exp_t e);
        if (o == 0) q0.push_back(e); else q1.push_back(e);
    endfunction

    // Monitor: measures each output pulse and compares with the scoreboard.
    always @(negedge clk) begin
        for (int o = 0; o < 2; o++) begin
            if (!rst && trig_out[o] && !prev_o[o]) start_o[o] = cyc;
            if (!rst && !trig_out[o] && prev_o[o]) begin
                exp_t e;
                int   w;
                bit   have;
                w = cyc - start_o[o];
                have = (o == 0) ? (q0.size() > 0) : (q1.size() > 0);
                n_tests++;
                if (!have) begin
                    n_fail++;
                    $display("FAIL R4 out%0d unexpected pulse start=%0d width=%0d, expected none", o, start_o[o], w);
                end else begin
                    e = (o == 0) ? q0.pop_front() : q1.pop_front();
                    if (e.start != start_o[o] || e.width != w) begin
                        n_fail++;
                        $display("FAIL %s out%0d start=%0d width=%0d, expected start=%0d width=%0d",
                                 e.req, o, start_o[o], w, e.start, e.width);
                    end
                end
            end
            prev_o[o] = rst ? 1'b0 : trig_out[o];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: raise one channel for 'hold' cycles and predict the pulses.
    task automatic fire(input int ch, input int hold, input string req);
        int s;
        @(negedge clk);
        s = cyc + 1;
        for (int o = 0; o < 2; o++) begin
            if (out_mask[o*3 + ch/16] && chan_en[ch] && s >= ready[o]) begin
                push_exp(o, '{start: s, width: hw + 2, req: req});
                ready[o] = s + hw + dw + 5;
            end
        end
        disc_in[ch] = 1'b1;
        repeat (hold) @(negedge clk);
        disc_in[ch] = 1'b0;
    endtask

    task automatic do_out_rst(input int h, input int d);
        int s;
        @(negedge clk);
        high_sel = 4'(h);
        dead_sel = 4'(d);
        out_rst  = 1'b1;
        s = cyc + 1;
        for (int o = 0; o < 2; o++) begin
            exp_t e;
            int   sz;
            sz = (o == 0) ? q0.size() : q1.size();
            if (sz > 0) begin
                e = (o == 0) ? q0[sz-1] : q1[sz-1];
                if (e.start <= s - 1 && e.start + e.width > s) begin
                    e.width = s - e.start;
                    e.req   = "R7";
                    if (o == 0) q0[sz-1] = e; else q1[sz-1] = e;
                end
            end
            ready[o] = s + 1;
        end
        hw = h;
        dw = d;
        @(negedge clk);
        out_rst = 1'b0;
        check(trig_out == 2'b00, "R7 outputs low after out_rst", int'(trig_out), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        ready[0] = 0; ready[1] = 0;
        prev_o[0] = 1'b0; prev_o[1] = 1'b0;
        start_o[0] = 0; start_o[1] = 0;
        repeat (3) @(negedge clk);
        check(trig_out == 2'b00, "R9 outputs low in reset", int'(trig_out), 0);
        rst = 1'b0;
        idle(2);
        check(trig_out == 2'b00, "R9 outputs low after reset", int'(trig_out), 0);

        // R1/R8: front all groups, back group B only; default timing N=0 (R6)
        out_mask = {3'b010, 3'b111};
        fire(0, 1, "R1");  idle(8);
        fire(20, 1, "R8"); idle(8);
        fire(40, 1, "R1"); idle(8);

        // R2: disabled channel contributes nothing
        chan_en[40] = 1'b0;
        fire(40, 1, "R2"); idle(8);
        check(q0.size() == 0 && q1.size() == 0, "R2 no pulse from disabled channel",
              q0.size() + q1.size(), 0);
        chan_en[40] = 1'b1;
        chan_en[3]  = 1'b0;
        fire(3, 2, "R2");  idle(8);
        chan_en[3]  = 1'b1;

        // R6: new fields without out_rst leave width unchanged
        high_sel = 4'd5; dead_sel = 4'd3;
        fire(1, 1, "R6");  idle(12);
        do_out_rst(5, 3);
        fire(1, 1, "R3");  idle(16);

        // R4: edges during high and dead time are dropped
        for (int i = 0; i < 10; i++) fire(22, 1, "R4");
        idle(20);

        // R5: a held level gives a single pulse
        fire(35, 30, "R5"); idle(16);

        // R7: output reset in mid pulse, new timing
        fire(18, 1, "R7");
        idle(2);
        do_out_rst(1, 0);
        fire(18, 1, "R3"); idle(10);
        fire(5, 1, "R3");  idle(10);

        // R8: back output masked off completely
        out_mask = {3'b000, 3'b100};
        fire(21, 1, "R8"); idle(6);
        fire(45, 1, "R8"); idle(12);

        idle(10);
        check(q0.size() == 0, "R3 all front pulses seen", q0.size(), 0);
        check(q1.size() == 0, "R8 all back pulses seen", q1.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule